// File: doc/BRIEF.md
# Single-Cycle Byte-Coded Processor with Immediate Add

This block is a small single-cycle processor for a byte-encoded 64-bit instruction set. It holds its own byte-addressed instruction memory. Each clock it fetches one variable-length instruction at the program counter and decodes the opcode, the register fields and an optional little-endian 8-byte constant. It reads a fifteen-entry register file and runs one ALU that also produces zero, sign and overflow flags. It then writes the result back and moves the program counter past the instruction. The supported set is stop, no-operation, constant-to-register load, register-to-register arithmetic and logic, and an add-constant-to-register instruction. The last one saves programs from spending a register on a constant.

Software loads the program as a byte stream while `run` is low. It then raises `run`, and the core steps until it either stops on a halt or rejects an instruction. The resulting state stays frozen until `run` is lowered again, and it can be read through a debug register port. Stream rules: a program byte is taken on a rising clock edge when `prog_valid` and `prog_ready` are both high. `prog_ready` is high exactly while `run` is low, so the core applies back-pressure for as long as it executes. A source must hold its byte and address until the byte is taken.

Top module: `cpu_seq`

## Requirements
- R1: After reset the program counter is 0, status is running (code 0), the flag vector `{zero,sign,overflow}` is 3'b100, every register reads 0 and every instruction byte is 0.
- R2: A program byte is written only on an edge where `prog_valid` and `prog_ready` are both high. `prog_ready` equals the inverse of `run`, so a byte offered while `run` is high is dropped.
- R3: Encoding: byte 0 carries the opcode in bits 7:4 and the function in bits 3:0. Byte 1 carries the first register in bits 7:4 and the second register in bits 3:0. A constant occupies bytes 2..9 with the least significant byte first. Opcodes: 0 halt, 1 nop, 3 load constant, 6 ALU operation, C add constant. Register code F means "no register".
- R4: Load constant (0x30, 0xF<rB>, V) writes V to rB, is 10 bytes long and leaves the flags unchanged.
- R5: An ALU operation (0x6<fn>, <rA><rB>) writes rB op rA to rB and is 2 bytes long. fn 0 adds, fn 1 computes rB minus rA, fn 2 is AND and fn 3 is XOR.
- R6: Add constant (0xC0, 0xF<rB>, V) writes rB + V to rB and is 10 bytes long.
- R7: ALU operations and add constant set the zero flag (result 0) and the sign flag (result bit 63). They set the overflow flag on two's-complement overflow of an add or subtract, and clear it for AND and XOR.
- R8: After an accepted non-halting instruction the program counter advances by 1, plus 1 when a register byte is present, plus 8 when a constant is present.
- R9: A halt (byte 0x00) sets status 1 and leaves the program counter on the halt's own address.
- R10: Status 2 (invalid) is raised, with no register, flag or counter change, in these cases: an unknown opcode; a nonzero function for halt, nop, load constant or add constant; an ALU function above 3; rA not F for load constant or add constant; rA equal to F for an ALU operation; rB equal to F; or an instruction that would extend past the last memory byte.
- R11: Once status is not 0 and `run` stays high, the program counter, registers, flags and status do not change.
- R12: One edge with `run` low returns the program counter to 0 and status to 0, and keeps the registers and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to execute, low to load and restart |
| prog_valid | input | 1 | Program byte offered |
| prog_ready | output | 1 | Program byte can be taken (high while `run` is low) |
| prog_addr | input | 6 | Byte address for the offered program byte |
| prog_byte | input | 8 | Program byte |
| dbg_sel | input | 4 | Register number to read out |
| dbg_val | output | 64 | Value of the selected register (0 for code F) |
| pc | output | 64 | Program counter |
| cc | output | 3 | Flags `{zero,sign,overflow}` |
| status | output | 2 | 0 running, 1 halted, 2 invalid instruction |

## Verification
Every instruction completes in the edge that samples it, so its register write, its flag update and the new counter are all visible one edge after the counter reached its address. The first instruction's results appear one edge after `run` rises. The bench drives on falling edges and samples only on falling edges, one half period after each change. It steps one cycle at a time until status leaves 0, so the final state is compared in the first cycle it can exist. A lowered `run` is checked one edge later, and the frozen state is rechecked several cycles after the stop.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;
  localparam int XLEN = 64;

  localparam logic [3:0] OPC_HALT  = 4'h0;
  localparam logic [3:0] OPC_NOP   = 4'h1;
  localparam logic [3:0] OPC_LDC   = 4'h3;
  localparam logic [3:0] OPC_ALU   = 4'h6;
  localparam logic [3:0] OPC_ADDC  = 4'hC;
  localparam logic [3:0] REG_NONE  = 4'hF;

  localparam logic [1:0] FN_ADD = 2'd0;
  localparam logic [1:0] FN_SUB = 2'd1;
  localparam logic [1:0] FN_AND = 2'd2;
  localparam logic [1:0] FN_XOR = 2'd3;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_HLT = 2'd1,
    ST_BAD = 2'd2
  } stat_e;

  typedef struct packed {
    logic [3:0]      opc;
    logic [3:0]      fn;
    logic [3:0]      ra;
    logic [3:0]      rb;
    logic [XLEN-1:0] konst;
  } instr_t;
endpackage

// File: rtl/cpu_seq_fetch.sv
module cpu_seq_fetch
  import cpu_seq_pkg::*;
#(
  parameter int IMEM_BYTES = 64,
  parameter int MAX_LEN    = 10,
  localparam int AW        = $clog2(IMEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_byte,
  input  logic [AW-1:0] pc_lo,
  output instr_t        ins
);
  logic [7:0] mem [IMEM_BYTES];
  logic [7:0] win [MAX_LEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IMEM_BYTES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_byte;
    end
  end

  for (genvar k = 0; k < MAX_LEN; k++) begin : g_win
    assign win[k] = mem[pc_lo + AW'(k)];
  end

  always_comb begin
    ins.opc = win[0][7:4];
    ins.fn  = win[0][3:0];
    ins.ra  = win[1][7:4];
    ins.rb  = win[1][3:0];
    for (int j = 0; j < 8; j++) ins.konst[8*j +: 8] = win[j+2];
  end
endmodule

// File: rtl/cpu_seq_regfile.sv
module cpu_seq_regfile #(
  parameter int NREG = 15,
  parameter int W    = 64,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wid,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] id_a,
  input  logic [IW-1:0] id_b,
  input  logic [IW-1:0] id_d,
  output logic [W-1:0]  val_a,
  output logic [W-1:0]  val_b,
  output logic [W-1:0]  val_d
);
  logic [W-1:0] regs [NREG];

  function automatic logic [W-1:0] rd(input logic [IW-1:0] id);
    logic [W-1:0] v;
    v = '0;
    for (int i = 0; i < NREG; i++) if (id == IW'(i)) v = regs[i];
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NREG; i++) if (wid == IW'(i)) regs[i] <= wdata;
    end
  end

  assign val_a = rd(id_a);
  assign val_b = rd(id_b);
  assign val_d = rd(id_d);
endmodule

// File: rtl/cpu_seq_alu.sv
module cpu_seq_alu
  import cpu_seq_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] res,
  output logic [2:0]   flags
);
  logic ovf;

  always_comb begin
    ovf = 1'b0;
    case (fn)
      FN_ADD: begin
        res = b + a;
        ovf = (a[W-1] == b[W-1]) && (res[W-1] != b[W-1]);
      end
      FN_SUB: begin
        res = b - a;
        ovf = (a[W-1] != b[W-1]) && (res[W-1] != b[W-1]);
      end
      FN_AND:  res = b & a;
      default: res = b ^ a;
    endcase
    flags = {res == '0, res[W-1], ovf};
  end
endmodule

// File: rtl/cpu_seq.sv
module cpu_seq
  import cpu_seq_pkg::*;
#(
  parameter int IMEM_BYTES = 64,
  parameter int NREG       = 15,
  localparam int AW        = $clog2(IMEM_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            prog_valid,
  output logic            prog_ready,
  input  logic [AW-1:0]   prog_addr,
  input  logic [7:0]      prog_byte,
  input  logic [3:0]      dbg_sel,
  output logic [XLEN-1:0] dbg_val,
  output logic [XLEN-1:0] pc,
  output logic [2:0]      cc,
  output logic [1:0]      status
);
  instr_t          ins;
  logic            has_reg, has_const, legal, fits, ok, writes, sets_cc;
  logic [3:0]      len;
  logic [XLEN:0]   end_addr;
  logic [XLEN-1:0] va, vb, alu_a, alu_res, wdata;
  logic [1:0]      alu_fn;
  logic [2:0]      alu_flags;
  logic            step, we;
  stat_e           st_q;

  assign prog_ready = !run;

  cpu_seq_fetch #(.IMEM_BYTES(IMEM_BYTES)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prog_valid && prog_ready), .wr_addr(prog_addr), .wr_byte(prog_byte),
    .pc_lo(pc[AW-1:0]), .ins(ins)
  );

  always_comb begin
    has_reg   = ins.opc inside {OPC_LDC, OPC_ALU, OPC_ADDC};
    has_const = ins.opc inside {OPC_LDC, OPC_ADDC};
    len       = 4'd1 + {3'b0, has_reg} + (has_const ? 4'd8 : 4'd0);
    end_addr  = {1'b0, pc} + (XLEN+1)'(len);
    fits      = end_addr <= (XLEN+1)'(IMEM_BYTES);
    case (ins.opc)
      OPC_HALT, OPC_NOP: legal = (ins.fn == 4'h0);
      OPC_LDC, OPC_ADDC: legal = (ins.fn == 4'h0) && (ins.ra == REG_NONE) && (ins.rb != REG_NONE);
      OPC_ALU:           legal = (ins.fn <= 4'h3) && (ins.ra != REG_NONE) && (ins.rb != REG_NONE);
      default:           legal = 1'b0;
    endcase
    ok      = legal && fits;
    writes  = has_reg;
    sets_cc = ins.opc inside {OPC_ALU, OPC_ADDC};
  end

  cpu_seq_regfile #(.NREG(NREG), .W(XLEN), .IW(4)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(we), .wid(ins.rb), .wdata(wdata),
    .id_a(ins.ra), .id_b(ins.rb), .id_d(dbg_sel),
    .val_a(va), .val_b(vb), .val_d(dbg_val)
  );

  assign alu_a  = (ins.opc == OPC_ADDC) ? ins.konst : va;
  assign alu_fn = (ins.opc == OPC_ADDC) ? FN_ADD : ins.fn[1:0];

  cpu_seq_alu #(.W(XLEN)) u_alu (
    .a(alu_a), .b(vb), .fn(alu_fn), .res(alu_res), .flags(alu_flags)
  );

  assign step  = run && (st_q == ST_RUN);
  assign we    = step && ok && writes;
  assign wdata = (ins.opc == OPC_LDC) ? ins.konst : alu_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      st_q <= ST_RUN;
      cc   <= 3'b100;
    end else if (!run) begin
      pc   <= '0;
      st_q <= ST_RUN;
    end else if (st_q == ST_RUN) begin
      if (!ok) begin
        st_q <= ST_BAD;
      end else if (ins.opc == OPC_HALT) begin
        st_q <= ST_HLT;
      end else begin
        pc <= pc + XLEN'(len);
        if (sets_cc) cc <= alu_flags;
      end
    end
  end

  assign status = st_q;
endmodule

// File: rtl/cpu_seq_chk.sv
module cpu_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [63:0] pc,
  input logic [2:0]  cc,
  input logic [1:0]  status
);
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && status != 2'd0) ##1 run |-> ($stable(pc) && $stable(cc) && $stable(status))); // R11

  AST_RUN_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc == 64'd0 && status == 2'd0)); // R12

  AST_HALT_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (run && status == 2'd0) ##1 (status == 2'd1) |-> $stable(pc)); // R9

  AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && status == 2'd0) ##1 (status == 2'd2) |-> ($stable(pc) && $stable(cc))); // R10

  AST_PC_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && status == 2'd0) ##1 (status == 2'd0) |->
      ((pc - $past(pc)) inside {64'd1, 64'd2, 64'd10})); // R8

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd3); // R10
endmodule

bind cpu_seq cpu_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pc(pc), .cc(cc), .status(status)
);

// File: tb/cpu_seq_tb.sv
module cpu_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, run = 1'b0, prog_valid = 1'b0;
  logic        prog_ready;
  logic [5:0]  prog_addr = '0;
  logic [7:0]  prog_byte = '0;
  logic [3:0]  dbg_sel = '0;
  logic [63:0] dbg_val, pc;
  logic [2:0]  cc;
  logic [1:0]  status;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [63:0] m_reg [15];
  logic [2:0]  m_cc;
  logic [63:0] m_pc;
  logic [1:0]  m_st;
  logic [7:0]  prog [MEMB];
  int          plen;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_seq u_dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_byte(prog_byte),
    .dbg_sel(dbg_sel), .dbg_val(dbg_val),
    .pc(pc), .cc(cc), .status(status)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference arithmetic in 65-bit signed form.
  task automatic model_alu(input logic [1:0] fn, input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] r, output logic [2:0] f);
    logic signed [64:0] w;
    logic ov;
    ov = 1'b0;
    case (fn)
      2'd0: begin w = $signed({b[63], b}) + $signed({a[63], a}); r = w[63:0]; ov = w[64] != w[63]; end
      2'd1: begin w = $signed({b[63], b}) - $signed({a[63], a}); r = w[63:0]; ov = w[64] != w[63]; end
      2'd2: r = a & b;
      default: r = a ^ b;
    endcase
    f = {r == 64'd0, r[63], ov};
  endtask

  task automatic new_prog();
    plen = 0;
    for (int i = 0; i < 15; i++) m_reg[i] = '0;
    for (int i = 0; i < MEMB; i++) prog[i] = '0;
    m_cc = 3'b100; m_pc = '0; m_st = 2'd0;
  endtask

  task automatic put(input logic [7:0] b);
    prog[plen] = b; plen++;
  endtask

  task automatic put_k(input logic [63:0] v);
    for (int j = 0; j < 8; j++) put(v[8*j +: 8]);
  endtask

  task automatic e_nop();
    put(8'h10);
    if (m_st == 0) m_pc += 1;
  endtask

  task automatic e_halt();
    put(8'h00);
    if (m_st == 0) m_st = 2'd1;
  endtask

  task automatic e_ldc(input logic [3:0] rb, input logic [63:0] v);
    put(8'h30); put({4'hF, rb}); put_k(v);
    if (m_st == 0) begin m_reg[rb] = v; m_pc += 10; end
  endtask

  task automatic e_addc(input logic [3:0] rb, input logic [63:0] v);
    logic [63:0] r; logic [2:0] f;
    put(8'hC0); put({4'hF, rb}); put_k(v);
    if (m_st == 0) begin
      model_alu(2'd0, v, m_reg[rb], r, f);
      m_reg[rb] = r; m_cc = f; m_pc += 10;
    end
  endtask

  task automatic e_op(input logic [1:0] fn, input logic [3:0] ra, input logic [3:0] rb);
    logic [63:0] r; logic [2:0] f;
    put({4'h6, 2'b00, fn}); put({ra, rb});
    if (m_st == 0) begin
      model_alu(fn, m_reg[ra], m_reg[rb], r, f);
      m_reg[rb] = r; m_cc = f; m_pc += 2;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; prog_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_prog();
    for (int i = 0; i < plen; i++) begin
      prog_valid = 1'b1; prog_addr = 6'(i); prog_byte = prog[i];
      @(negedge clk);
    end
    prog_valid = 1'b0;
  endtask

  task automatic go_wait();
    run = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 80 && status == 2'd0; c++) @(negedge clk);
  endtask

  task automatic chk_state(input string req);
    chk(req, "status", 64'(status), 64'(m_st));
    chk(req, "pc", pc, m_pc);
    chk(req, "flags", 64'(cc), 64'(m_cc));
    for (int i = 0; i < 15; i++) begin
      dbg_sel = 4'(i); #1;
      chk(req, $sformatf("reg%0d", i), dbg_val, m_reg[i]);
    end
  endtask

  task automatic run_prog(input string req);
    do_reset();
    load_prog();
    chk("R2", "ready while loading", 64'(prog_ready), 64'd1);
    go_wait();
    chk("R2", "ready while running", 64'(prog_ready), 64'd0);
    chk_state(req);
    repeat (3) @(negedge clk);
    chk("R11", "frozen pc", pc, m_pc);
    chk("R11", "frozen status", 64'(status), 64'(m_st));
    chk("R11", "frozen flags", 64'(cc), 64'(m_cc));
    run = 1'b0;
    @(negedge clk);
    chk("R12", "restart pc", pc, 64'd0);
    chk("R12", "restart status", 64'(status), 64'd0);
    chk("R12", "flags kept", 64'(cc), 64'(m_cc));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] av [4];
    logic [63:0] bv [4];
    logic [15:0] bad [10];
    logic [3:0]  ras [3];
    logic [3:0]  rbs [3];
    av  = '{64'd5, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'd3};
    bv  = '{64'hFFFF_FFFF_FFFF_FFFB, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4};
    bad = '{16'h50F2, 16'hC002, 16'hC1F2, 16'h6412, 16'h601F,
            16'h60F1, 16'h3002, 16'h30FF, 16'h0100, 16'hC0FF};
    ras = '{4'd0, 4'd3, 4'd14};
    rbs = '{4'd1, 4'd14, 4'd3};

    // R1: reset state
    new_prog();
    do_reset();
    chk_state("R1");
    dbg_sel = 4'hF; #1;
    chk("R1", "no-register readout", dbg_val, 64'd0);

    // R6 R7: add constant on every register, zero/overflow/plain sums
    for (int rb = 0; rb < 15; rb++) begin
      for (int k = 0; k < 4; k++) begin
        new_prog();
        e_ldc(4'(rb), av[k]);
        e_addc(4'(rb), bv[k]);
        e_halt();
        run_prog("R6");
      end
    end

    // R5 R7: register-to-register operations
    for (int fn = 0; fn < 4; fn++) begin
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < 3; i++) begin
          for (int j = 0; j < 3; j++) begin
            new_prog();
            e_ldc(ras[i], p == 0 ? 64'h0123_4567_89AB_CDEF : 64'd1);
            e_ldc(rbs[j], p == 0 ? 64'hFEDC_BA98_7654_3210 :
                          (fn == 1 ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF));
            e_op(2'(fn), ras[i], rbs[j]);
            e_halt();
            run_prog("R5");
          end
        end
      end
    end

    // R3: little-endian constants build a known value in register 0
    new_prog();
    e_addc(4'd0, 64'h0000_ABCD_0000_0000);
    e_addc(4'd0, 64'h0000_0000_ABCD_0000);
    e_addc(4'd0, 64'h0000_0000_0000_ABCD);
    e_halt();
    run_prog("R3");
    chk("R3", "built value", m_reg[0], 64'h0000_ABCD_ABCD_ABCD);

    // R4: load constant leaves flags alone
    new_prog();
    e_ldc(4'd9, 64'd0);
    e_ldc(4'd8, 64'h8000_0000_0000_0001);
    e_halt();
    run_prog("R4");

    // R8: mixed lengths
    new_prog();
    e_nop(); e_ldc(4'd2, 64'd10); e_nop(); e_addc(4'd2, 64'd7);
    e_op(2'd3, 4'd2, 4'd5); e_op(2'd1, 4'd2, 4'd5); e_nop(); e_halt();
    run_prog("R8");

    // R9: halt after two nops stays at address 2
    new_prog();
    e_nop(); e_nop(); e_halt();
    run_prog("R9");

    // R10: rejected encodings leave state as it was
    for (int b = 0; b < 10; b++) begin
      new_prog();
      e_ldc(4'd2, 64'h55);
      put(bad[b][15:8]); put(bad[b][7:0]); put_k(64'd0);
      m_st = 2'd2;
      run_prog("R10");
    end

    // R10: instruction running past the last byte
    new_prog();
    for (int i = 0; i < 60; i++) e_nop();
    put(8'hC0); put(8'hF1); put(8'h01); put(8'h00);
    m_st = 2'd2;
    run_prog("R10");

    // R2: a byte offered while running is dropped
    new_prog();
    e_nop(); e_halt();
    do_reset();
    load_prog();
    go_wait();
    prog_valid = 1'b1; prog_addr = 6'd0; prog_byte = 8'h00;
    @(negedge clk);
    chk("R2", "ready low while running", 64'(prog_ready), 64'd0);
    prog_valid = 1'b0;
    run = 1'b0;
    @(negedge clk);
    go_wait();
    chk("R2", "program intact pc", pc, 64'd1);
    chk("R2", "program intact status", 64'(status), 64'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule